// File: doc/BRIEF.md
# Transmit power level mapper

This block turns two requested transmit power levels, one for the direct-sequence (CCK) modulator and one for the OFDM modulator, into the register writes that program them. When `start` is pulsed it samples both levels, the channel number and the board type. Each level is limited to the range the board type allows and then split by six: the quotient picks a coarse gain step and the remainder picks a fine entry from a small internal table.

The block then issues fifteen single-byte writes on a request/acknowledge port, in a fixed order. The first nine program the CCK path: one coarse gain byte, then eight filter coefficients. After a programmable settling pause, three fixed setup writes go to the OFDM baseband, followed by the OFDM coarse gain byte and the OFDM fine byte, which is written to two registers. A second pause follows, and then `done` pulses for one cycle. On channel 14 the coefficients come from an alternate table that narrows the CCK spectrum.

Top module: `txpm_power_mapper`

## Requirements
- R1: After reset `wr_req`, `busy` and `done` are 0.
- R2: `start` is acted on only while `busy` is 0. A `start` pulse seen while `busy` is 1, including the cycle of `done`, changes neither the sequence in progress nor the levels it uses, and produces no further writes.
- R3: The CCK level is limited to 11 when `board_narrow`=1 and to 35 when it is 0. Write 0 goes to space MAC (`wr_space`=0), address 0x9D, with data (2 << coarse) - 1, where coarse = limited level / 6. Coarse steps 0..5 therefore give 0x01, 0x03, 0x07, 0x0F, 0x1F and 0x3F.
- R4: Writes 1 to 8 go to space CCK (`wr_space`=1), addresses 0x44 to 0x4B in ascending order. Their data are the eight coefficients of table row fine = limited level mod 6.
- R5: When `channel`=14, the alternate coefficient table is used. Its first three columns match the normal table, its fourth column is {0x0C,0x0E,0x0F,0x11,0x13,0x15} by row, and its last four columns are 0.
- R6: For the OFDM level, the board range is min 10 / max 25 when `board_narrow`=1 and min 0 / max 35 when it is 0. A level above max-min becomes max; any other level has min added. The result is then limited to 35. Write 12 goes to space MAC, address 0x9E, with data (2 << coarse) - 1 taken from this result.
- R7: Writes 9, 10 and 11 go to space OFDM (`wr_space`=2) and set register 0x02 to 0x42, 0x06 to 0x00 and 0x08 to 0x00, in that order.
- R8: Writes 13 and 14 go to space OFDM, registers 0x05 and then 0x07. Both carry the fine byte from {0x80,0x90,0xA2,0xB5,0xCB,0xE4}, indexed by the OFDM result mod 6.
- R9: After the acknowledge of write 8, `wr_req` stays low for exactly WAIT_CYCLES cycles. After the acknowledge of write 14, `done` rises after exactly WAIT_CYCLES cycles. No other gap separates consecutive writes.
- R10: While `wr_req` is 1 and `wr_ack` is 0, `wr_space`, `wr_addr` and `wr_data` hold steady. Each acknowledged cycle completes exactly one write.
- R11: `done` is high for a single cycle, and `busy` is 0 in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that samples the inputs and begins a sequence |
| board_narrow | input | 1 | 1 selects the narrow-range board limits, 0 the wide-range limits |
| channel | input | 4 | Channel number; 14 selects the alternate coefficient table |
| cck_level | input | LEVEL_W | Requested CCK power level |
| ofdm_level | input | LEVEL_W | Requested OFDM power level |
| wr_req | output | 1 | Write request, held until acknowledged |
| wr_ack | input | 1 | Write acknowledge; the write completes on a clock edge with wr_req and wr_ack both high |
| wr_space | output | 2 | Target: 0 MAC register, 1 CCK baseband, 2 OFDM baseband |
| wr_addr | output | 8 | Register address within the target |
| wr_data | output | 8 | Byte to write |
| busy | output | 1 | High from the accepted start until after done |
| done | output | 1 | One-cycle pulse ending the sequence |

## Verification
Two things can land in the same cycle: a new `start` request and the final steps of the sequence already running. The overlap occurs when `start` arrives together with the acknowledge of the last CCK coefficient, or together with the `done` pulse itself. The bench provokes both cases and drives fresh, different levels alongside each stray `start`. It then judges the outcome by checking three things: every remaining write of the running sequence still matches the originally sampled levels, exactly one `done` appears, and `wr_req` stays low afterwards. Acknowledge latency is varied across writes at the same time, so that stray starts coincide with both held and completing requests.

// File: rtl/txpm_pkg.sv
package txpm_pkg;

  typedef enum logic [1:0] {
    SPACE_MAC  = 2'd0,
    SPACE_CCK  = 2'd1,
    SPACE_OFDM = 2'd2
  } wr_space_e;

  localparam int unsigned COEF_TAPS       = 8;
  localparam int unsigned SPLIT_DIV       = 6;
  localparam int unsigned LEVEL_CEIL      = 35;
  localparam int unsigned CCK_MAX_NARROW  = 11;
  localparam int unsigned CCK_MAX_WIDE    = 35;
  localparam int unsigned OFDM_MIN_NARROW = 10;
  localparam int unsigned OFDM_MAX_NARROW = 25;
  localparam int unsigned OFDM_MIN_WIDE   = 0;
  localparam int unsigned OFDM_MAX_WIDE   = 35;

  // Limit a CCK request to the board's ceiling.
  function automatic logic [5:0] cck_effective(input int unsigned lvl, input logic narrow);
    int unsigned top;
    top = narrow ? CCK_MAX_NARROW : CCK_MAX_WIDE;
    return 6'((lvl > top) ? top : lvl);
  endfunction

  // Two-stage OFDM adjustment: offset-or-saturate, then global ceiling.
  function automatic logic [5:0] ofdm_effective(input int unsigned lvl, input logic narrow);
    int unsigned lo, hi, v;
    lo = narrow ? OFDM_MIN_NARROW : OFDM_MIN_WIDE;
    hi = narrow ? OFDM_MAX_NARROW : OFDM_MAX_WIDE;
    if (lvl > (hi - lo)) v = hi;
    else                 v = lvl + lo;
    if (v > LEVEL_CEIL)  v = LEVEL_CEIL;
    return 6'(v);
  endfunction

  function automatic logic [2:0] coarse_of(input logic [5:0] v);
    return 3'(v / 6'(SPLIT_DIV));
  endfunction

  function automatic logic [2:0] fine_of(input logic [5:0] v);
    return 3'(v % 6'(SPLIT_DIV));
  endfunction

  // Coarse gain step table; the programmed byte is this value halved.
  function automatic logic [7:0] gain_step(input logic [2:0] c);
    case (c)
      3'd0:    return 8'h02;
      3'd1:    return 8'h06;
      3'd2:    return 8'h0E;
      3'd3:    return 8'h1E;
      3'd4:    return 8'h3E;
      default: return 8'h7E;
    endcase
  endfunction

  function automatic logic [7:0] ofdm_fine_byte(input logic [2:0] f);
    case (f)
      3'd0:    return 8'h80;
      3'd1:    return 8'h90;
      3'd2:    return 8'hA2;
      3'd3:    return 8'hB5;
      3'd4:    return 8'hCB;
      default: return 8'hE4;
    endcase
  endfunction

  // CCK filter rows, tap 0 in the most significant byte.
  function automatic logic [63:0] coef_row_std(input logic [2:0] f);
    case (f)
      3'd0:    return 64'h18_17_15_11_0C_08_04_02;
      3'd1:    return 64'h1B_1A_17_13_0E_09_04_02;
      3'd2:    return 64'h1F_1E_1A_15_10_0A_05_02;
      3'd3:    return 64'h22_21_1D_18_11_0B_06_02;
      3'd4:    return 64'h26_25_21_1B_14_0D_06_03;
      default: return 64'h2B_2A_25_1E_16_0E_07_03;
    endcase
  endfunction

  function automatic logic [63:0] coef_row_narrowband(input logic [2:0] f);
    case (f)
      3'd0:    return 64'h18_17_15_0C_00_00_00_00;
      3'd1:    return 64'h1B_1A_17_0E_00_00_00_00;
      3'd2:    return 64'h1F_1E_1A_0F_00_00_00_00;
      3'd3:    return 64'h22_21_1D_11_00_00_00_00;
      3'd4:    return 64'h26_25_21_13_00_00_00_00;
      default: return 64'h2B_2A_25_15_00_00_00_00;
    endcase
  endfunction

endpackage

// File: rtl/txpm_level_split.sv
module txpm_level_split
  import txpm_pkg::*;
#(
  parameter int unsigned LEVEL_W = 8
) (
  input  logic               board_narrow,
  input  logic [LEVEL_W-1:0] cck_level,
  input  logic [LEVEL_W-1:0] ofdm_level,
  output logic [2:0]         cck_coarse,
  output logic [2:0]         cck_fine,
  output logic [2:0]         ofdm_coarse,
  output logic [2:0]         ofdm_fine
);

  logic [5:0] cck_eff;
  logic [5:0] ofdm_eff;

  always_comb begin
    cck_eff     = cck_effective(32'(cck_level), board_narrow);
    ofdm_eff    = ofdm_effective(32'(ofdm_level), board_narrow);
    cck_coarse  = coarse_of(cck_eff);
    cck_fine    = fine_of(cck_eff);
    ofdm_coarse = coarse_of(ofdm_eff);
    ofdm_fine   = fine_of(ofdm_eff);
  end

endmodule

// File: rtl/txpm_byte_tables.sv
module txpm_byte_tables
  import txpm_pkg::*;
(
  input  logic [2:0] cck_coarse,
  input  logic [2:0] cck_fine,
  input  logic [2:0] ofdm_coarse,
  input  logic [2:0] ofdm_fine,
  input  logic       use_narrowband,
  output logic [7:0] cck_gain,
  output logic [7:0] ofdm_gain,
  output logic [7:0] ofdm_power,
  output logic [7:0] coef [COEF_TAPS]
);

  logic [63:0] row_std;
  logic [63:0] row_nb;

  always_comb begin
    cck_gain   = gain_step(cck_coarse) >> 1;
    ofdm_gain  = gain_step(ofdm_coarse) >> 1;
    ofdm_power = ofdm_fine_byte(ofdm_fine);
    row_std    = coef_row_std(cck_fine);
    row_nb     = coef_row_narrowband(cck_fine);
  end

  for (genvar k = 0; k < COEF_TAPS; k++) begin : g_tap
    localparam int unsigned HI = 63 - 8 * k;
    assign coef[k] = use_narrowband ? row_nb[HI -: 8] : row_std[HI -: 8];
  end

endmodule

// File: rtl/txpm_seq.sv
module txpm_seq #(
  parameter int unsigned WAIT_CYCLES = 100000,
  parameter int unsigned CCK_WRITES  = 9,
  parameter int unsigned ALL_WRITES  = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       wr_ack,
  output logic       wr_req,
  output logic [3:0] step,
  output logic       load,
  output logic       busy,
  output logic       done
);

  localparam int unsigned CNT_W = $clog2(WAIT_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_PAUSE, S_DONE} seq_state_e;

  seq_state_e       state;
  logic [CNT_W-1:0] pause_cnt;
  logic             phase_last;
  logic             pause_over;

  assign phase_last = (step == 4'(CCK_WRITES - 1)) || (step == 4'(ALL_WRITES - 1));
  assign pause_over = (pause_cnt == CNT_W'(WAIT_CYCLES - 1));

  assign wr_req = (state == S_WRITE);
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_DONE);
  assign load   = (state == S_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      step      <= '0;
      pause_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            step  <= '0;
            state <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (wr_ack) begin
            step <= step + 4'd1;
            if (phase_last) begin
              pause_cnt <= '0;
              state     <= S_PAUSE;
            end
          end
        end
        S_PAUSE: begin
          if (pause_over) begin
            state <= (step == 4'(ALL_WRITES)) ? S_DONE : S_WRITE;
          end else begin
            pause_cnt <= pause_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txpm_power_mapper.sv
module txpm_power_mapper
  import txpm_pkg::*;
#(
  parameter int unsigned LEVEL_W        = 8,
  parameter int unsigned WAIT_CYCLES    = 100000,
  parameter logic [7:0]  CCK_GAIN_ADDR  = 8'h9D,
  parameter logic [7:0]  OFDM_GAIN_ADDR = 8'h9E,
  parameter logic [3:0]  ALT_CHANNEL    = 4'd14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               board_narrow,
  input  logic [3:0]         channel,
  input  logic [LEVEL_W-1:0] cck_level,
  input  logic [LEVEL_W-1:0] ofdm_level,
  output logic               wr_req,
  input  logic               wr_ack,
  output logic [1:0]         wr_space,
  output logic [7:0]         wr_addr,
  output logic [7:0]         wr_data,
  output logic               busy,
  output logic               done
);

  localparam int unsigned CCK_WRITES = 1 + COEF_TAPS;
  localparam int unsigned ALL_WRITES = CCK_WRITES + 6;
  localparam logic [7:0]  COEF_BASE  = 8'h44;

  logic [2:0] cck_coarse_d, cck_fine_d, ofdm_coarse_d, ofdm_fine_d;
  logic [2:0] cck_coarse_q, cck_fine_q, ofdm_coarse_q, ofdm_fine_q;
  logic       ch14_q;
  logic       load;
  logic [3:0] step;
  logic [3:0] tap_idx;
  logic       wr_fire;
  logic [7:0] cck_gain, ofdm_gain, ofdm_power;
  logic [7:0] coef [COEF_TAPS];
  wr_space_e  space_sel;

  assign wr_fire = wr_req && wr_ack;

  txpm_level_split #(.LEVEL_W(LEVEL_W)) split_i (
    .board_narrow (board_narrow),
    .cck_level    (cck_level),
    .ofdm_level   (ofdm_level),
    .cck_coarse   (cck_coarse_d),
    .cck_fine     (cck_fine_d),
    .ofdm_coarse  (ofdm_coarse_d),
    .ofdm_fine    (ofdm_fine_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cck_coarse_q  <= '0;
      cck_fine_q    <= '0;
      ofdm_coarse_q <= '0;
      ofdm_fine_q   <= '0;
      ch14_q        <= 1'b0;
    end else if (load) begin
      cck_coarse_q  <= cck_coarse_d;
      cck_fine_q    <= cck_fine_d;
      ofdm_coarse_q <= ofdm_coarse_d;
      ofdm_fine_q   <= ofdm_fine_d;
      ch14_q        <= (channel == ALT_CHANNEL);
    end
  end

  txpm_byte_tables tables_i (
    .cck_coarse     (cck_coarse_q),
    .cck_fine       (cck_fine_q),
    .ofdm_coarse    (ofdm_coarse_q),
    .ofdm_fine      (ofdm_fine_q),
    .use_narrowband (ch14_q),
    .cck_gain       (cck_gain),
    .ofdm_gain      (ofdm_gain),
    .ofdm_power     (ofdm_power),
    .coef           (coef)
  );

  txpm_seq #(
    .WAIT_CYCLES (WAIT_CYCLES),
    .CCK_WRITES  (CCK_WRITES),
    .ALL_WRITES  (ALL_WRITES)
  ) seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .wr_ack (wr_ack),
    .wr_req (wr_req),
    .step   (step),
    .load   (load),
    .busy   (busy),
    .done   (done)
  );

  // Write list: step number selects target, address and byte.
  assign tap_idx = step - 4'd1;

  always_comb begin
    space_sel = SPACE_OFDM;
    wr_addr   = 8'h00;
    wr_data   = 8'h00;
    case (step)
      4'd0: begin
        space_sel = SPACE_MAC;
        wr_addr   = CCK_GAIN_ADDR;
        wr_data   = cck_gain;
      end
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8: begin
        space_sel = SPACE_CCK;
        wr_addr   = COEF_BASE + {5'd0, tap_idx[2:0]};
        wr_data   = coef[tap_idx[2:0]];
      end
      4'd9:  begin wr_addr = 8'h02; wr_data = 8'h42; end
      4'd10: begin wr_addr = 8'h06; wr_data = 8'h00; end
      4'd11: begin wr_addr = 8'h08; wr_data = 8'h00; end
      4'd12: begin
        space_sel = SPACE_MAC;
        wr_addr   = OFDM_GAIN_ADDR;
        wr_data   = ofdm_gain;
      end
      4'd13: begin wr_addr = 8'h05; wr_data = ofdm_power; end
      4'd14: begin wr_addr = 8'h07; wr_data = ofdm_power; end
      default: begin wr_addr = 8'h00; wr_data = 8'h00; end
    endcase
  end

  assign wr_space = space_sel;

endmodule

// File: rtl/txpm_checker.sv
module txpm_checker #(
  parameter int unsigned WAIT_CYCLES = 100000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       wr_req,
  input logic       wr_ack,
  input logic       wr_fire,
  input logic [1:0] wr_space,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       ch14_q
);

  localparam int unsigned GAP_W = $clog2(WAIT_CYCLES + 2);

  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              gap_cnt <= '0;
    else if (wr_fire)                        gap_cnt <= '0;
    else if (gap_cnt != GAP_W'(WAIT_CYCLES + 1)) gap_cnt <= gap_cnt + 1'b1;
  end

  // R1 is judged at the ports by the bench right after reset.

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  assert_cck_gain_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_space == 2'd0) |-> ($countones(wr_data + 8'd1) == 1));

  assert_coef_ascend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_space == 2'd1 && wr_addr >= 8'h44 && wr_addr < 8'h4B)
      |=> (wr_req && wr_space == 2'd1 && wr_addr == $past(wr_addr) + 8'd1));

  assert_alt_tail_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && ch14_q && wr_space == 2'd1 && wr_addr >= 8'h48) |-> (wr_data == 8'h00));

  assert_fine_twice_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_space == 2'd2 && wr_addr == 8'h05)
      |=> (wr_req && wr_space == 2'd2 && wr_addr == 8'h07 && $stable(wr_data)));

  assert_mid_pause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wr_req) && wr_space == 2'd2 && wr_addr == 8'h02) |-> (gap_cnt == GAP_W'(WAIT_CYCLES)));

  assert_end_pause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (gap_cnt == GAP_W'(WAIT_CYCLES)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data) && $stable(wr_space)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

bind txpm_power_mapper txpm_checker #(.WAIT_CYCLES(WAIT_CYCLES)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .wr_req   (wr_req),
  .wr_ack   (wr_ack),
  .wr_fire  (wr_fire),
  .wr_space (wr_space),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .ch14_q   (ch14_q)
);

// File: tb/txpm_power_mapper_tb_top.sv
`timescale 1ns/1ps
module txpm_power_mapper_tb_top;

  localparam int W = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       board_narrow = 1'b0;
  logic [3:0] channel = 4'd1;
  logic [7:0] cck_level = 8'd0;
  logic [7:0] ofdm_level = 8'd0;
  logic       wr_ack = 1'b0;
  logic       wr_req;
  logic [1:0] wr_space;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       busy;
  logic       done;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  txpm_power_mapper #(.WAIT_CYCLES(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .board_narrow(board_narrow),
    .channel(channel), .cck_level(cck_level), .ofdm_level(ofdm_level),
    .wr_req(wr_req), .wr_ack(wr_ack), .wr_space(wr_space), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done)
  );

  // Reference coefficient table, 6 rows of 8 taps.
  byte unsigned std_tab [48] = '{
    8'h18,8'h17,8'h15,8'h11,8'h0C,8'h08,8'h04,8'h02,
    8'h1B,8'h1A,8'h17,8'h13,8'h0E,8'h09,8'h04,8'h02,
    8'h1F,8'h1E,8'h1A,8'h15,8'h10,8'h0A,8'h05,8'h02,
    8'h22,8'h21,8'h1D,8'h18,8'h11,8'h0B,8'h06,8'h02,
    8'h26,8'h25,8'h21,8'h1B,8'h14,8'h0D,8'h06,8'h03,
    8'h2B,8'h2A,8'h25,8'h1E,8'h16,8'h0E,8'h07,8'h03};
  byte unsigned nb_col3 [6] = '{8'h0C,8'h0E,8'h0F,8'h11,8'h13,8'h15};
  byte unsigned fine_tab [6] = '{8'h80,8'h90,8'hA2,8'hB5,8'hCB,8'hE4};

  int e_space [15];
  int e_addr  [15];
  int e_data  [15];
  string e_req [15];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic build_expect(input int c, input int o, input int ch, input bit nar);
    int ce, oe, lo, hi, cc, cf, oc, of_;
    ce = nar ? (c > 11 ? 11 : c) : (c > 35 ? 35 : c);
    cc = ce / 6; cf = ce % 6;
    lo = nar ? 10 : 0; hi = nar ? 25 : 35;
    oe = (o > hi - lo) ? hi : o + lo;
    if (oe > 35) oe = 35;
    oc = oe / 6; of_ = oe % 6;
    e_space[0] = 0; e_addr[0] = 'h9D; e_data[0] = (2 << cc) - 1; e_req[0] = "R3";
    for (int k = 0; k < 8; k++) begin
      e_space[k+1] = 1; e_addr[k+1] = 'h44 + k;
      if (ch == 14) begin
        e_data[k+1] = (k < 3) ? std_tab[cf*8+k] : (k == 3 ? nb_col3[cf] : 0);
        e_req[k+1] = "R5";
      end else begin
        e_data[k+1] = std_tab[cf*8+k];
        e_req[k+1] = "R4";
      end
    end
    e_space[9]  = 2; e_addr[9]  = 2; e_data[9]  = 'h42; e_req[9]  = "R7";
    e_space[10] = 2; e_addr[10] = 6; e_data[10] = 0;    e_req[10] = "R7";
    e_space[11] = 2; e_addr[11] = 8; e_data[11] = 0;    e_req[11] = "R7";
    e_space[12] = 0; e_addr[12] = 'h9E; e_data[12] = (2 << oc) - 1; e_req[12] = "R6";
    e_space[13] = 2; e_addr[13] = 5; e_data[13] = fine_tab[of_]; e_req[13] = "R8";
    e_space[14] = 2; e_addr[14] = 7; e_data[14] = fine_tab[of_]; e_req[14] = "R8";
  endtask

  // One full sequence; stray starts injected when meddle is set (R2).
  task automatic run_one(input int c, input int o, input int ch, input bit nar, input bit meddle);
    int gap;
    build_expect(c, o, ch, nar);
    @(negedge clk);
    cck_level = 8'(c); ofdm_level = 8'(o); channel = 4'(ch); board_narrow = nar;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 15; w++) begin
      gap = 0;
      while (!wr_req && gap < 200) begin gap++; @(negedge clk); end
      if (w == 9) check(gap == W, "R9", gap, W);
      else        check(gap == 0, "R9", gap, 0);
      check(wr_space == 2'(e_space[w]), e_req[w], wr_space, e_space[w]);
      check(wr_addr == 8'(e_addr[w]), e_req[w], wr_addr, e_addr[w]);
      check(wr_data == 8'(e_data[w]), e_req[w], wr_data, e_data[w]);
      for (int d = 0; d < (w + c) % 3; d++) begin
        @(negedge clk);
        check(wr_req && wr_addr == 8'(e_addr[w]) && wr_data == 8'(e_data[w]),
              "R10", {wr_addr, wr_data}, {e_addr[w][7:0], e_data[w][7:0]});
      end
      wr_ack = 1'b1;
      if (meddle && w == 8) begin
        start = 1'b1; cck_level = 8'(c + 17); ofdm_level = 8'(o + 9);
        channel = (ch == 14) ? 4'd3 : 4'd14; board_narrow = ~nar;
      end
      @(negedge clk);
      wr_ack = 1'b0; start = 1'b0;
    end
    gap = 0;
    while (!done && gap < 200) begin gap++; @(negedge clk); end
    check(gap == W, "R9", gap, W);
    if (meddle) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done && !busy, "R11", {done, busy}, 0);
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      check(!wr_req && !busy, "R2", {wr_req, busy}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!wr_req && !busy && !done, "R1", {wr_req, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wr_req && !busy && !done, "R1", {wr_req, busy, done}, 0);
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 48; i++) begin
        run_one(i, (i * 7) % 48, (i % 2 == 1) ? 14 : (i % 13) + 1, b[0], (i % 8 == 3));
      end
    end
    run_one(255, 255, 14, 1'b0, 1'b1);
    run_one(255, 255, 2, 1'b1, 1'b0);
    run_one(12, 15, 14, 1'b1, 1'b0);
    run_one(36, 16, 7, 1'b1, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule